// File: doc/BRIEF.md
# Chainable Event Counter Bank

This block counts hardware events for one cache slice. A vector of single-cycle event pulses enters the bank. Each of the eight 32-bit counters picks one of those pulses through its own 8-bit selector, and it adds one on every cycle in which that pulse is high, as long as the global run bit and its own count-enable bit are both set.

Counters sit in even/odd pairs. When the gang bit of an odd counter is set, that counter stops following its own event and counts the wraps of its even partner instead, so the pair acts as one 64-bit counter. The carry lands on the same clock edge as the wrap, so the two halves always read back as one consistent value.

Every counting step that flips a counter's top bit, from 0 to 1 or from 1 to 0, sets a sticky status bit. Because of this, a 32-bit counter can run freely and software can still follow how often it wraps. A masked OR of the status bits drives a single interrupt line. Software reaches every register through a flat word-addressed write/read port.

Top module: `evctr_bank`

## Requirements
- R1: After reset the run bit, gang, interrupt-enable, status and count-enable registers, every selector and every counter read zero, and irq_o is low.
- R2: With run set and count-enable bit i set, counter i adds one on each cycle where its selector is k (1..NUM_EVT) and evt_i[k-1] is high. A selector value of 0 never counts, and a counter whose enable bit is 0 holds its value.
- R3: Control bit 0 (run) cleared stops every counter. A control write with bit 1 set zeroes all counters on that edge. Bit 1 is not stored and reads back as 0.
- R4: Gang bit 2k+1 set makes counter 2k+1 add one on exactly the edge where counter 2k wraps from all ones to zero. The odd counter's own selector and enable are then ignored. Even gang bits are ignored and read as zero.
- R5: With gang bit 2k+1 clear, a wrap of counter 2k leaves counter 2k+1 unchanged.
- R6: A counting step that changes a counter's most significant bit in either direction sets status bit i. A software write to a counter never sets status.
- R7: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. If a toggle and a clear hit the same bit on the same edge, the bit ends set.
- R8: irq_o is high exactly when some status bit and its interrupt-enable bit are both set.
- R9: A write to counter i loads the written value, and it takes priority over an increment on the same edge.
- R10: Word addresses: 0 control, 1 gang, 2 interrupt enable, 3 status, 4 count enable, 16+i counter i, 32+i selector i (low 8 bits). Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_EVT | Event pulses, one cycle per occurrence |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | CTR_W | Write data |
| reg_rdata_o | output | CTR_W | Read data for reg_addr_i (combinational) |
| irq_o | output | 1 | Masked OR of the status bits |

## Verification
The bench keeps the default eight 32-bit counters and shrinks the event vector to four lines (NUM_EVT=4). This keeps the stimulus table short while still covering selector value 0, a disabled counter and two counters that count at the same time. Wraps and top-bit toggles in both directions come from preloading counters through the write port to values next to the boundary. This reaches full 32-bit carries and 64-bit chaining in a few cycles. Same-edge conflicts (write against increment, status clear against toggle) are driven on purpose.

// File: rtl/evctr_pkg.sv
package evctr_pkg;
    localparam int SEL_W     = 8;
    localparam int ADR_CTRL  = 0;
    localparam int ADR_GANG  = 1;
    localparam int ADR_IEN   = 2;
    localparam int ADR_STAT  = 3;
    localparam int ADR_CEN   = 4;
    localparam int ADR_CNT0  = 16;
    localparam int ADR_SEL0  = 32;
    localparam int CTRL_RUN  = 0;
    localparam int CTRL_CLR  = 1;
endpackage

// File: rtl/evctr_evsel.sv
module evctr_evsel #(
    parameter int NUM_EVT = 32,
    parameter int SEL_W   = 8
) (
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [NUM_EVT-1:0] evt_i,
    output logic               hit_o
);
    // Selector 0 means no event; value k picks line k-1.
    always_comb begin
        hit_o = 1'b0;
        for (int j = 0; j < NUM_EVT; j++) begin
            if (sel_i == SEL_W'(j + 1)) hit_o = evt_i[j];
        end
    end
endmodule

// File: rtl/evctr_lane.sv
module evctr_lane #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         wr_i,
    input  logic         clr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] cnt_o,
    output logic         toggle_o
);
    logic [W-1:0] cnt_d, cnt_q, cnt_inc;
    logic         step;

    always_comb begin
        cnt_inc  = cnt_q + W'(1);
        step     = inc_i & ~wr_i & ~clr_i;
        cnt_d    = cnt_q;
        if (clr_i)     cnt_d = '0;
        else if (wr_i) cnt_d = wdata_i;
        else if (step) cnt_d = cnt_inc;
        toggle_o = step & (cnt_inc[W-1] ^ cnt_q[W-1]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R9: a software write lands exactly
    a_r9_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clr_i) |=> (cnt_q == $past(wdata_i)));

    // R2: without write or clear the counter holds or steps by one
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && !clr_i) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + W'(1)));
endmodule

// File: rtl/evctr_bank.sv
module evctr_bank
    import evctr_pkg::*;
#(
    parameter int NUM_CTR = 8,
    parameter int CTR_W   = 32,
    parameter int NUM_EVT = 32,
    parameter int ADDR_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               reg_wr_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [CTR_W-1:0]   reg_wdata_i,
    output logic [CTR_W-1:0]   reg_rdata_o,
    output logic               irq_o
);
    localparam int NUM_PAIR = NUM_CTR / 2;

    function automatic logic [NUM_CTR-1:0] odd_mask();
        logic [NUM_CTR-1:0] m;
        for (int i = 0; i < NUM_CTR; i++) m[i] = (i % 2) == 1;
        return m;
    endfunction
    localparam logic [NUM_CTR-1:0] ODD_MASK = odd_mask();

    typedef struct packed {
        logic                          run;
        logic [NUM_CTR-1:0]            gang;
        logic [NUM_CTR-1:0]            ien;
        logic [NUM_CTR-1:0]            stat;
        logic [NUM_CTR-1:0]            cen;
        logic [NUM_CTR-1:0][SEL_W-1:0] sel;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_CTR-1:0]            hit, base_inc, inc, cnt_wr, toggle;
    logic [NUM_PAIR-1:0]           carry;
    logic [NUM_CTR-1:0][CTR_W-1:0] cnt;
    logic                          clr_all;

    // Strobes decoded from the register port
    always_comb begin
        clr_all = reg_wr_i && (reg_addr_i == ADDR_W'(ADR_CTRL)) && reg_wdata_i[CTRL_CLR];
        for (int i = 0; i < NUM_CTR; i++)
            cnt_wr[i] = reg_wr_i && (reg_addr_i == ADDR_W'(ADR_CNT0 + i));
    end

    // Next-state for control and status
    always_comb begin
        ctl_d = ctl_q;
        if (reg_wr_i) begin
            case (reg_addr_i)
                ADDR_W'(ADR_CTRL): ctl_d.run  = reg_wdata_i[CTRL_RUN];
                ADDR_W'(ADR_GANG): ctl_d.gang = reg_wdata_i[NUM_CTR-1:0] & ODD_MASK;
                ADDR_W'(ADR_IEN):  ctl_d.ien  = reg_wdata_i[NUM_CTR-1:0];
                ADDR_W'(ADR_STAT): ctl_d.stat = ctl_q.stat & ~reg_wdata_i[NUM_CTR-1:0];
                ADDR_W'(ADR_CEN):  ctl_d.cen  = reg_wdata_i[NUM_CTR-1:0];
                default: begin
                    for (int i = 0; i < NUM_CTR; i++)
                        if (reg_addr_i == ADDR_W'(ADR_SEL0 + i))
                            ctl_d.sel[i] = reg_wdata_i[SEL_W-1:0];
                end
            endcase
        end
        ctl_d.stat = ctl_d.stat | toggle;   // a new toggle beats a clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // Per-counter lanes
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_lane
        evctr_evsel #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_sel (
            .sel_i (ctl_q.sel[i]),
            .evt_i (evt_i),
            .hit_o (hit[i])
        );

        assign base_inc[i] = ctl_q.run & ctl_q.cen[i] & hit[i];

        if (i % 2 == 1) begin : g_odd
            assign inc[i] = ctl_q.gang[i] ? carry[i/2] : base_inc[i];
        end else begin : g_even
            assign inc[i] = base_inc[i];
        end

        evctr_lane #(.W(CTR_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc_i    (inc[i]),
            .wr_i     (cnt_wr[i]),
            .clr_i    (clr_all),
            .wdata_i  (reg_wdata_i),
            .cnt_o    (cnt[i]),
            .toggle_o (toggle[i])
        );

        // R7: status stays set unless a 1 is written to it
        a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_q.stat[i] && !(reg_wr_i && reg_addr_i == ADDR_W'(ADR_STAT) && reg_wdata_i[i]))
            |=> ctl_q.stat[i]);
    end

    // Even counters wrap: carry into the odd partner on the same edge
    for (genvar k = 0; k < NUM_PAIR; k++) begin : g_pair
        assign carry[k] = base_inc[2*k] & ~cnt_wr[2*k] & ~clr_all & (&cnt[2*k]);

        // R4: a chained odd half steps on the wrap edge of its partner
        a_r4_chain_carry: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_q.gang[2*k+1] && carry[k] && !cnt_wr[2*k+1])
            |=> (cnt[2*k+1] == $past(cnt[2*k+1]) + CTR_W'(1)) && (cnt[2*k] == '0));

        // R5: an unchained odd half ignores its partner
        a_r5_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctl_q.gang[2*k+1] && !base_inc[2*k+1] && !reg_wr_i) |=> $stable(cnt[2*k+1]));
    end

    // Read mux
    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            ADDR_W'(ADR_CTRL): reg_rdata_o = CTR_W'(ctl_q.run);
            ADDR_W'(ADR_GANG): reg_rdata_o = CTR_W'(ctl_q.gang);
            ADDR_W'(ADR_IEN):  reg_rdata_o = CTR_W'(ctl_q.ien);
            ADDR_W'(ADR_STAT): reg_rdata_o = CTR_W'(ctl_q.stat);
            ADDR_W'(ADR_CEN):  reg_rdata_o = CTR_W'(ctl_q.cen);
            default: begin
                for (int i = 0; i < NUM_CTR; i++) begin
                    if (reg_addr_i == ADDR_W'(ADR_CNT0 + i)) reg_rdata_o = cnt[i];
                    if (reg_addr_i == ADDR_W'(ADR_SEL0 + i)) reg_rdata_o = CTR_W'(ctl_q.sel[i]);
                end
            end
        endcase
    end

    assign irq_o = |(ctl_q.stat & ctl_q.ien);

    // R3: stopped bank without writes keeps every counter
    a_r3_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.run && !reg_wr_i) |=> $stable(cnt));
endmodule

// File: tb/tb_evctr_bank.sv
module tb_evctr_bank;
    localparam int NUM_CTR = 8;
    localparam int CTR_W   = 32;
    localparam int NUM_EVT = 4;
    localparam int ADDR_W  = 6;
    localparam time TCLK   = 20ns;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_EVT-1:0] evt = '0;
    logic               reg_wr = 1'b0;
    logic [ADDR_W-1:0]  reg_addr = '0;
    logic [CTR_W-1:0]   reg_wdata = '0;
    logic [CTR_W-1:0]   reg_rdata;
    logic               irq;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    evctr_bank #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .NUM_EVT(NUM_EVT), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq)
    );

    always #(TCLK/2) clk = ~clk;

    localparam int A_CTRL = 0, A_GANG = 1, A_IEN = 2, A_STAT = 3, A_CEN = 4;
    localparam int A_CNT = 16, A_SEL = 32;

    // Stimulus table: event pattern, expected counters 0 and 1 afterwards
    localparam int NV = 6;
    localparam logic [3:0] T_EVT [NV] = '{4'b0001, 4'b0011, 4'b0010, 4'b0000, 4'b0111, 4'b0110};
    localparam int         T_C0  [NV] = '{1, 2, 2, 2, 3, 3};
    localparam int         T_C1  [NV] = '{0, 1, 2, 2, 3, 4};

    task automatic check(input string req, input logic [CTR_W-1:0] got, input logic [CTR_W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [CTR_W-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [CTR_W-1:0] d);
        reg_addr = ADDR_W'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [NUM_EVT-1:0] e);
        @(negedge clk);
        evt = e;
        @(negedge clk);
        evt = '0;
    endtask

    initial begin
        #(TCLK * 200000);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [CTR_W-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, v);  check("R1 ctrl", v, 0);
        rd(A_STAT, v);  check("R1 stat", v, 0);
        rd(A_CNT+0, v); check("R1 cnt0", v, 0);
        rd(A_SEL+0, v); check("R1 sel0", v, 0);
        check("R1 irq", CTR_W'(irq), 0);

        // Setup: sel0=1, sel1=2, sel2=0, sel3=3; enable 0..2 only
        wr(A_SEL+0, 1); wr(A_SEL+1, 2); wr(A_SEL+2, 0); wr(A_SEL+3, 3);
        wr(A_CEN, 32'h07);
        wr(A_CTRL, 32'h1);
        rd(A_SEL+1, v); check("R10 sel1 readback", v, 2);

        // R2 table walk
        for (int i = 0; i < NV; i++) begin
            pulse(T_EVT[i]);
            rd(A_CNT+0, v); check("R2 cnt0", v, CTR_W'(T_C0[i]));
            rd(A_CNT+1, v); check("R2 cnt1", v, CTR_W'(T_C1[i]));
            rd(A_CNT+2, v); check("R2 sel zero", v, 0);
            rd(A_CNT+3, v); check("R2 disabled", v, 0);
        end

        // R3 stop
        wr(A_CTRL, 32'h0);
        pulse(4'b1111);
        rd(A_CNT+0, v); check("R3 stopped", v, 3);

        // R9 write beats increment
        wr(A_CTRL, 32'h1);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = ADDR_W'(A_CNT+0); reg_wdata = 100; evt = 4'b0001;
        @(negedge clk);
        reg_wr = 1'b0; evt = '0;
        rd(A_CNT+0, v); check("R9 write priority", v, 100);

        // R3 clear all
        wr(A_CTRL, 32'h3);
        rd(A_CTRL, v);  check("R3 clear bit not stored", v, 1);
        rd(A_CNT+0, v); check("R3 clear cnt0", v, 0);
        rd(A_CNT+1, v); check("R3 clear cnt1", v, 0);

        // R4 chaining pair 0/1
        wr(A_GANG, 32'h0F);
        rd(A_GANG, v); check("R4 even gang bits ignored", v, 32'h0A);
        wr(A_CEN, 32'h33);
        wr(A_CNT+0, 32'hFFFF_FFFE);
        pulse(4'b0011);
        rd(A_CNT+0, v); check("R4 low half", v, 32'hFFFF_FFFF);
        rd(A_CNT+1, v); check("R4 own event ignored", v, 0);
        rd(A_STAT, v);  check("R6 write sets no status", v, 0);
        pulse(4'b0011);
        rd(A_CNT+0, v); check("R4 low wrapped", v, 0);
        rd(A_CNT+1, v); check("R4 carry same edge", v, 1);
        rd(A_STAT, v);  check("R6 falling toggle", v, 32'h01);

        // R5 unchained pair 4/5
        wr(A_SEL+4, 1); wr(A_SEL+5, 0);
        wr(A_CNT+4, 32'hFFFF_FFFF);
        pulse(4'b0001);
        rd(A_CNT+4, v); check("R5 even wrapped", v, 0);
        rd(A_CNT+5, v); check("R5 odd unchanged", v, 0);
        rd(A_STAT, v);  check("R6 status both", v, 32'h11);

        // R8 interrupt masking
        check("R8 irq masked", CTR_W'(irq), 0);
        wr(A_IEN, 32'h10);
        check("R8 irq raised", CTR_W'(irq), 1);

        // R7 write one to clear
        wr(A_STAT, 32'h10);
        rd(A_STAT, v); check("R7 w1c", v, 32'h01);
        check("R8 irq dropped", CTR_W'(irq), 0);

        // R6 rising toggle
        wr(A_CNT+4, 32'h7FFF_FFFF);
        pulse(4'b0001);
        rd(A_CNT+4, v); check("R6 rising value", v, 32'h8000_0000);
        rd(A_STAT, v);  check("R6 rising toggle", v, 32'h11);

        // R7 set beats clear on the same edge
        wr(A_CNT+4, 32'hFFFF_FFFF);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = ADDR_W'(A_STAT); reg_wdata = 32'h10; evt = 4'b0001;
        @(negedge clk);
        reg_wr = 1'b0; evt = '0;
        rd(A_STAT, v); check("R7 set wins", v, 32'h11);

        // R10 unmapped
        rd(5, v); check("R10 unmapped", v, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule